// File: doc/BRIEF.md
# Flash Status Poller

This block waits on a serial flash device by reading its one-byte status register over and over until a chosen field holds a chosen value. A pulse on `start_i` captures a mask, an expected value and a retry budget. The block then issues status-read requests to a transaction engine and inspects each returned byte. It stops when `(status & mask) == expect`, or when the budget of reads has been used up without a match. The SPI signalling is the engine's job. Which field to wait on is the caller's choice: the write-enable latch wait uses mask 0x02 with expected 0x02, and the busy wait uses mask 0x01 with expected 0x00.

The control is a four-state machine:
- `ST_IDLE` moves to `ST_ISSUE` on start.
- `ST_ISSUE` presents a request and moves to `ST_WAIT` when the engine accepts it.
- `ST_WAIT` takes the response byte. A matching byte goes to `ST_FIN`. A mismatch with budget left goes back to `ST_ISSUE`. A mismatch on the last budgeted read goes to `ST_FIN`.
- `ST_FIN` raises done for one cycle and returns to `ST_IDLE`.

Top module: `flash_stat_poller`

## Requirements
- R1: After reset the block is idle: `req_valid_o`, `done_o`, `success_o`, `timeout_o` and `busy_o` are 0, and `last_status_o` is 0x00.
- R2: Each poll iteration raises `req_valid_o` with `req_cmd_o` = 0x05 and holds both unchanged until `req_ready_i` is seen high; exactly one response byte is consumed per accepted request.
- R3: A response with `(rsp_data_i & mask) == expect` ends polling: `done_o` is high in the cycle after that response is taken, with `success_o` = 1.
- R4: A non-matching response with budget remaining causes a new request, raised in the cycle after the response.
- R5: If `limit` reads complete without a match, `done_o` rises with `timeout_o` = 1 after exactly `limit` requests; a limit of 0 is treated as 1.
- R6: When the final budgeted read matches, the outcome is success, not timeout.
- R7: `done_o` is high for exactly one cycle, with exactly one of `success_o`/`timeout_o` set; both flags keep their values until the next accepted start.
- R8: A start pulse while `busy_o` is high is ignored: mask, expected value and budget are not reloaded.
- R9: `last_status_o` shows the most recently received status byte, and it is valid when `done_o` is high.
- R10: Mask and expected value are captured at start; changes on `mask_i`/`expect_i` during a poll have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mask_i | input | 8 | Field mask applied to each status byte |
| expect_i | input | 8 | Value the masked field must equal |
| limit_i | input | CNT_W | Maximum number of status reads (0 acts as 1) |
| req_valid_o | output | 1 | Status-read request valid |
| req_cmd_o | output | 8 | Command byte for the request (0x05) |
| req_ready_i | input | 1 | Engine accepts the request |
| rsp_valid_i | input | 1 | Status byte returned |
| rsp_data_i | input | 8 | Returned status byte |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| success_o | output | 1 | Poll ended on a match |
| timeout_o | output | 1 | Budget exhausted without a match |
| last_status_o | output | 8 | Most recent status byte |

## Verification
An accepted start shows on `req_valid_o` one cycle later. A request accepted at an edge is followed by `ST_WAIT` at the next cycle, and the bench answers with a response byte there. A terminating response is followed by `done_o` exactly one cycle later. A non-terminating response is followed by a new request one cycle later. The bench drives on falling edges and samples at the next falling edge after each edge of interest. It checks that a done arrives only in the cycle right after a response, and that it is gone in the cycle that follows.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_FIN   = 2'd3
    } poll_state_t;

    localparam logic [7:0] CMD_READ_STATUS = 8'h05;
endpackage

// File: rtl/sp_mask_match.sv
module sp_mask_match #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    input  logic [DW-1:0] mask_i,
    input  logic [DW-1:0] want_i,
    output logic          hit_o
);
    always_comb hit_o = ((data_i & mask_i) == want_i);
endmodule

// File: rtl/sp_retry_ctr.sv
module sp_retry_ctr #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             dec_i,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (limit_i == '0) ? ONE : limit_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    always_comb last_o = (cnt_q == ONE);

    // R5: the budget never wraps below one remaining read
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (cnt_q > ONE));
endmodule

// File: rtl/flash_stat_poller.sv
module flash_stat_poller
    import sp_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       mask_i,
    input  logic [7:0]       expect_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             req_valid_o,
    output logic [7:0]       req_cmd_o,
    input  logic             req_ready_i,
    input  logic             rsp_valid_i,
    input  logic [7:0]       rsp_data_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             success_o,
    output logic             timeout_o,
    output logic [7:0]       last_status_o
);
    poll_state_t state_q, state_d;
    logic [7:0]  mask_q, want_q, last_q;
    logic        succ_q, tmo_q;
    logic        hit, budget_last, accept, take_rsp;

    always_comb accept   = (state_q == ST_IDLE) && start_i;
    always_comb take_rsp = (state_q == ST_WAIT) && rsp_valid_i;

    sp_mask_match #(.DW(8)) match_i (
        .data_i (rsp_data_i),
        .mask_i (mask_q),
        .want_i (want_q),
        .hit_o  (hit)
    );

    sp_retry_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .limit_i (limit_i),
        .dec_i   (take_rsp && !hit && !budget_last),
        .last_o  (budget_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready_i) state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid_i) state_d = (hit || budget_last) ? ST_FIN : ST_ISSUE;
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured operands and outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            want_q <= '0;
            last_q <= '0;
            succ_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (accept) begin
            mask_q <= mask_i;
            want_q <= expect_i;
            succ_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else if (take_rsp) begin
            last_q <= rsp_data_i;
            if (hit)              succ_q <= 1'b1;
            else if (budget_last) tmo_q  <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        req_valid_o   = (state_q == ST_ISSUE);
        req_cmd_o     = CMD_READ_STATUS;
        busy_o        = (state_q != ST_IDLE);
        done_o        = (state_q == ST_FIN);
        success_o     = succ_q;
        timeout_o     = tmo_q;
        last_status_o = last_q;
    end

    // R2: request held until accepted
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_cmd_o)));
    // R2: command byte is the status read
    p_req_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_cmd_o == 8'h05));
    // R7: one-cycle done with exactly one outcome
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (success_o ^ timeout_o));
    // R3: success only on a matching last byte
    p_success_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && success_o) |-> ((last_status_o & mask_q) == want_q));
    // R8: start while busy leaves operands unchanged
    p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(mask_q) && $stable(want_q)));
    // R9: last status updates only on a taken response
    p_last_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_rsp |=> $stable(last_status_o));
endmodule

// File: tb/flash_stat_poller_tb_top.sv
module flash_stat_poller_tb_top;
    localparam int CNT_W = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [7:0]       mask_i = '0;
    logic [7:0]       expect_i = '0;
    logic [CNT_W-1:0] limit_i = '0;
    logic             req_valid_o;
    logic [7:0]       req_cmd_o;
    logic             req_ready_i = 1'b0;
    logic             rsp_valid_i = 1'b0;
    logic [7:0]       rsp_data_i = '0;
    logic             busy_o, done_o, success_o, timeout_o;
    logic [7:0]       last_status_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] seq [0:15];

    always #2 clk = ~clk;

    flash_stat_poller #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
        .expect_i(expect_i), .limit_i(limit_i), .req_valid_o(req_valid_o),
        .req_cmd_o(req_cmd_o), .req_ready_i(req_ready_i), .rsp_valid_i(rsp_valid_i),
        .rsp_data_i(rsp_data_i), .busy_o(busy_o), .done_o(done_o),
        .success_o(success_o), .timeout_o(timeout_o), .last_status_o(last_status_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            finish_run();
        end
    end

    // Runs one poll; responses come from seq[]
    task automatic run_poll(input string tag, input logic [7:0] m, input logic [7:0] e,
                            input int lim, input int exp_reads, input logic exp_succ,
                            input int ready_delay, input logic inject);
        int nreads = 0;
        int phase = 0;
        int waitc = 0;
        logic resp_prev = 1'b0;
        logic seen_done = 1'b0;
        @(negedge clk);
        mask_i = m; expect_i = e; limit_i = CNT_W'(lim); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int t = 0; t < 400 && !seen_done; t++) begin
            req_ready_i = 1'b0; rsp_valid_i = 1'b0; start_i = 1'b0;
            if (done_o) begin
                seen_done = 1'b1;
                check({tag, " R3 done right after response"}, 32'(resp_prev), 32'd1);
            end else if (phase == 0 && req_valid_o) begin
                resp_prev = 1'b0;
                check({tag, " R2 cmd"}, 32'(req_cmd_o), 32'h05);
                if (inject && nreads == 1) begin
                    start_i = 1'b1; mask_i = 8'h00; expect_i = 8'h00; limit_i = CNT_W'(20);
                end
                if (waitc < ready_delay) waitc++;
                else begin req_ready_i = 1'b1; phase = 1; waitc = 0; end
            end else if (phase == 1) begin
                rsp_valid_i = 1'b1;
                rsp_data_i = seq[nreads];
                nreads++;
                phase = 0;
                resp_prev = 1'b1;
            end else begin
                resp_prev = 1'b0;
            end
            if (!seen_done) @(negedge clk);
        end
        check({tag, " R7 done seen"}, 32'(seen_done), 32'd1);
        check({tag, " R5 read count"}, nreads, exp_reads);
        check({tag, " R7 success flag"}, 32'(success_o), 32'(exp_succ));
        check({tag, " R7 timeout flag"}, 32'(timeout_o), 32'(!exp_succ));
        check({tag, " R9 last status"}, 32'(last_status_o), 32'(seq[exp_reads-1]));
        @(negedge clk);
        check({tag, " R7 done one cycle"}, 32'(done_o), 32'd0);
        @(negedge clk);
        check({tag, " R7 flags held"}, {success_o, timeout_o}, {exp_succ, !exp_succ});
        check({tag, " R4 no extra request"}, 32'(req_valid_o), 32'd0);
    endtask

    initial begin
        #1;
        check("R1 req_valid", 32'(req_valid_o), 0);
        check("R1 done", 32'(done_o), 0);
        check("R1 flags", {busy_o, success_o, timeout_o}, 0);
        check("R1 last", 32'(last_status_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 32'(busy_o), 0);

        // R3 R4: write-enable latch wait
        seq[0] = 8'h00; seq[1] = 8'h00; seq[2] = 8'h02;
        run_poll("wel", 8'h02, 8'h02, 10, 3, 1'b1, 0, 1'b0);

        // R3 R4: busy-clear wait
        seq[0] = 8'h03; seq[1] = 8'h01; seq[2] = 8'hFC;
        run_poll("wip", 8'h01, 8'h00, 10, 3, 1'b1, 0, 1'b0);

        // R5: budget runs out
        seq[0] = 8'h01; seq[1] = 8'h01; seq[2] = 8'h01; seq[3] = 8'h01;
        run_poll("tmo", 8'h01, 8'h00, 4, 4, 1'b0, 0, 1'b0);

        // R6: last budgeted read matches
        seq[0] = 8'h01; seq[1] = 8'h01; seq[2] = 8'h00;
        run_poll("lastmatch", 8'h01, 8'h00, 3, 3, 1'b1, 0, 1'b0);

        // R5: limit 0 acts as one read
        seq[0] = 8'hFF;
        run_poll("lim0", 8'h01, 8'h00, 0, 1, 1'b0, 0, 1'b0);

        // R2: request held while engine stalls
        seq[0] = 8'h5A;
        run_poll("stall", 8'hFF, 8'h5A, 5, 1, 1'b1, 3, 1'b0);

        // R8 R10: start and new operands during poll ignored
        seq[0] = 8'h01; seq[1] = 8'h01; seq[2] = 8'h01;
        run_poll("busystart", 8'h01, 8'h00, 3, 3, 1'b0, 0, 1'b1);

        finish_run();
    end
endmodule